// File: doc/BRIEF.md
# Gated Binary Seconds Counter

This block keeps a free-running binary count of elapsed seconds. A slow tick-enable input arrives at 32.768 kHz. A power-of-two prescaler divides it down so that the count moves by one once per second. Turning the count into a calendar date is left to host software. The crystal oscillator and the supply switching sit outside the block. Supply state reaches it as two digital flags: one says the part runs from its backup source, the other says the main supply has failed.

The host reaches the block through a register port built as two streams. A request stream carries a write flag, a 3-bit register address and a data byte. A response stream returns one byte for every accepted request. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a response is waiting that the host has not yet taken, and it is low throughout a power failure. Once raised, `rsp_valid` stays high and `rsp_rdata` stays unchanged until `rsp_ready` is seen high.

The count is held in four byte registers, least significant byte first. A control register holds a stop bit. When the stop bit is set, the count is frozen. On backup power the stop bit also halts the oscillator. On main power the oscillator keeps running and only the count is held.

Top module: `sec_counter`

## Requirements
- R1: After reset the count is 0, the prescaler is 0, the stop bit (register 4, bit 7) is 1, `rsp_valid` is low and `req_ready` is high.
- R2: While the stop bit is 0, the count rises by exactly one on the clock edge that completes 2^PRESCALE_W enabled ticks (`tick_en` high at a clock edge), counted from reset or from the last prescaler clear.
- R3: While the stop bit is 1 and `on_backup` is high, `osc_run` is low, the prescaler does not advance and the count does not change.
- R4: While the stop bit is 1 and `on_backup` is low, `osc_run` is high and the prescaler keeps advancing, but the count does not change. After the bit is cleared, the next increment arrives when the running prescaler completes its cycle.
- R5: Registers 0 to 3 hold count bits [7:0], [15:8], [23:16] and [31:24]. A read of register 0 returns the live low byte and copies the whole count into a shadow. Reads of registers 1 to 3 return the shadow bytes, so a carry between reads cannot mix two counts.
- R6: A write to register k (0 to 3) replaces count byte k with the data byte and leaves the other bytes unchanged. It clears the prescaler, and no increment happens in that cycle.
- R7: Register 4 reads as {stop bit, 7'b0}, and a write to it loads the stop bit from data bit 7. Registers 5 to 7 read as 0, and writes to them have no effect.
- R8: While `pwr_fail` is high, `req_ready` is low, so no request is accepted and the count and stop bit cannot be written.
- R9: Each accepted request yields exactly one response in the next cycle. A write returns 0, and a read returns the register value at the acceptance edge. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `req_ready` is low.
- R10: The count wraps from FFFFFFFFh to 00000000h on the increment after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| on_backup | input | 1 | High while the part runs from its backup supply |
| pwr_fail | input | 1 | High while the main supply is out of tolerance; blocks host access |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response stream valid |
| rsp_ready | input | 1 | Response stream ready |
| rsp_rdata | output | 8 | Read data (0 for writes) |
| osc_run | output | 1 | High while the oscillator is meant to run |

## Verification
The bench builds the block with PRESCALE_W = 3, so one second takes eight enabled ticks. With that setting, a prescaler wrap, a carry out of the low byte during a multi-byte read, and the full 32-bit rollover each take only a handful of cycles. Because the prescaler is this short, its phase after a stop period tells a frozen oscillator (backup power) from a running one (main power). It also shows whether a counter write cleared the prescaler.

// File: rtl/sec_counter_pkg.sv
package sec_counter_pkg;
  localparam int CNT_BYTES = 4;
  localparam int CNT_W     = CNT_BYTES * 8;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam logic [ADDR_W-1:0] REG_CTRL = 3'd4;
  localparam int STOP_BIT  = 7;
  localparam logic STOP_RESET = 1'b1;
endpackage

// File: rtl/sc_prescaler.sv
module sc_prescaler #(
  parameter int W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clr,
  output logic carry
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (adv) pre_q <= pre_q + ONE;
  end

  assign carry = adv && !clr && (&pre_q);
endmodule

// File: rtl/sc_count_core.sv
module sc_count_core
  import sec_counter_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc,
  input  logic                 wr_en,
  input  logic [CNT_BYTES-1:0] wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [CNT_W-1:0]     count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] bumped;
  logic [CNT_W-1:0] count_d;

  assign bumped = count_q + ONE;

  for (genvar k = 0; k < CNT_BYTES; k++) begin : g_byte
    always_comb begin
      if (wr_en) begin
        count_d[k*8 +: 8] = wr_sel[k] ? wr_data : count_q[k*8 +: 8];
      end else if (inc) begin
        count_d[k*8 +: 8] = bumped[k*8 +: 8];
      end else begin
        count_d[k*8 +: 8] = count_q[k*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/sc_host_port.sv
module sc_host_port
  import sec_counter_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_fail,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  input  logic [CNT_W-1:0]     count,
  output logic                 cnt_wr_en,
  output logic [CNT_BYTES-1:0] cnt_wr_sel,
  output logic                 stop
);
  logic                accept;
  logic                is_cnt;
  logic                rsp_valid_q;
  logic [DATA_W-1:0]   rsp_data_q;
  logic [DATA_W-1:0]   rd_val;
  logic [CNT_W-1:0]    shadow_q;
  logic                stop_q;

  assign req_ready = !pwr_fail && (!rsp_valid_q || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign is_cnt    = (req_addr < ADDR_W'(CNT_BYTES));
  assign cnt_wr_en = accept && req_write && is_cnt;

  for (genvar k = 0; k < CNT_BYTES; k++) begin : g_sel
    assign cnt_wr_sel[k] = (req_addr == ADDR_W'(k));
  end

  always_comb begin
    rd_val = '0;
    if (req_addr == '0) begin
      rd_val = count[7:0];
    end else if (req_addr == REG_CTRL) begin
      rd_val[STOP_BIT] = stop_q;
    end else begin
      for (int k = 1; k < CNT_BYTES; k++) begin
        if (req_addr == ADDR_W'(k)) rd_val = shadow_q[k*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      stop_q   <= STOP_RESET;
    end else if (accept) begin
      if (!req_write && req_addr == '0) shadow_q <= count;
      if (req_write && req_addr == REG_CTRL) stop_q <= req_wdata[STOP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= req_write ? '0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
  assign stop      = stop_q;
endmodule

// File: rtl/sec_counter.sv
module sec_counter
  import sec_counter_pkg::*;
#(
  parameter int PRESCALE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              on_backup,
  input  logic              pwr_fail,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              osc_run
);
  logic [CNT_W-1:0]     count;
  logic                 cnt_wr_en;
  logic [CNT_BYTES-1:0] cnt_wr_sel;
  logic                 stop;
  logic                 carry;

  assign osc_run = !(on_backup && stop);

  sc_host_port u_port (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .count(count), .cnt_wr_en(cnt_wr_en), .cnt_wr_sel(cnt_wr_sel), .stop(stop)
  );

  sc_prescaler #(.W(PRESCALE_W)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .adv(tick_en && osc_run), .clr(cnt_wr_en), .carry(carry)
  );

  sc_count_core u_core (
    .clk(clk), .rst_n(rst_n), .inc(carry && !stop),
    .wr_en(cnt_wr_en), .wr_sel(cnt_wr_sel), .wr_data(req_wdata),
    .count(count)
  );
endmodule

// File: rtl/sec_counter_chk.sv
module sec_counter_chk
  import sec_counter_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_fail,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [CNT_W-1:0]  count,
  input logic              stop,
  input logic              cnt_wr_en
);
  a_r8_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> !req_ready);
  a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> !cnt_wr_en);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  a_r9_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R3 and R4: a set stop bit freezes the count
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !cnt_wr_en) |=> $stable(count));
  // R2 and R10: without a write the count moves by at most one, modulo 2^32
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_en |=> (count == $past(count) || count == $past(count) + 32'd1));
endmodule

bind sec_counter sec_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .count(count), .stop(stop), .cnt_wr_en(cnt_wr_en)
);

// File: tb/tb_sec_counter.sv
module tb_sec_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       on_backup = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_rdata;
  logic       osc_run;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  sec_counter #(.PRESCALE_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .on_backup(on_backup),
    .pwr_fail(pwr_fail), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .osc_run(osc_run)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: pushes the expected response, then performs the handshake
  task automatic xfer(input logic wr, input logic [2:0] a, input logic [7:0] d,
                      input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rd_count(input logic [31:0] exp, input string tag);
    xfer(1'b0, 3'd0, 8'h00, exp[7:0], tag);
    xfer(1'b0, 3'd1, 8'h00, exp[15:8], tag);
    xfer(1'b0, 3'd2, 8'h00, exp[23:16], tag);
    xfer(1'b0, 3'd3, 8'h00, exp[31:24], tag);
  endtask

  task automatic wr_count(input logic [31:0] v, input string tag);
    for (int k = 0; k < 4; k++) xfer(1'b1, 3'(k), v[k*8 +: 8], 8'h00, tag);
  endtask

  // monitor: compares each response as the handshake completes
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected response", 32'(rsp_rdata), 32'hDEAD);
      end else begin
        check(tag_q.pop_front(), 32'(rsp_rdata), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 req_ready", 32'(req_ready), 1);
    check("R4 osc_run main power", 32'(osc_run), 1);
    xfer(1'b0, 3'd4, 8'h00, 8'h80, "R1 stop bit");
    rd_count(32'h0, "R1 count");

    // R3: backup power with stop bit set freezes the oscillator
    on_backup = 1'b1;
    @(negedge clk);
    check("R3 osc_run", 32'(osc_run), 0);
    ticks(20);
    rd_count(32'h0, "R3 count held");
    // R4: main power, oscillator runs, count held; phase kept
    on_backup = 1'b0;
    ticks(5);
    rd_count(32'h0, "R4 count held");
    xfer(1'b1, 3'd4, 8'h00, 8'h00, "R7 write ctrl");
    ticks(3);
    rd_count(32'h1, "R4 prescaler phase");
    ticks(16);
    rd_count(32'h3, "R2 two seconds");

    // R5/R6 byte order and writes
    wr_count(32'h12345678, "R6 write");
    rd_count(32'h12345678, "R5 byte order");
    ticks(5);
    xfer(1'b1, 3'd1, 8'h56, 8'h00, "R6 write clears prescaler");
    ticks(7);
    xfer(1'b0, 3'd0, 8'h00, 8'h78, "R6 prescaler cleared");
    ticks(1);
    xfer(1'b0, 3'd0, 8'h00, 8'h79, "R2 increment after clear");

    // R5 shadow against a carry between reads
    xfer(1'b1, 3'd0, 8'hFF, 8'h00, "R6 write low byte");
    xfer(1'b0, 3'd0, 8'h00, 8'hFF, "R5 capture");
    ticks(8);
    xfer(1'b0, 3'd1, 8'h00, 8'h56, "R5 shadow byte");
    rd_count(32'h12345700, "R5 new capture");

    // R10 rollover
    wr_count(32'hFFFFFFFF, "R10 write");
    ticks(8);
    rd_count(32'h0, "R10 wrap");

    // R7 control and unused registers
    xfer(1'b1, 3'd5, 8'hAA, 8'h00, "R7 write unused");
    xfer(1'b0, 3'd5, 8'h00, 8'h00, "R7 read unused 5");
    xfer(1'b0, 3'd7, 8'h00, 8'h00, "R7 read unused 7");
    rd_count(32'h0, "R7 unused write no effect");
    xfer(1'b1, 3'd4, 8'h7F, 8'h00, "R7 write ctrl low bits");
    xfer(1'b0, 3'd4, 8'h00, 8'h00, "R7 ctrl low bits read 0");
    xfer(1'b1, 3'd4, 8'hFF, 8'h00, "R7 write ctrl set");
    xfer(1'b0, 3'd4, 8'h00, 8'h80, "R7 ctrl readback");
    xfer(1'b1, 3'd4, 8'h00, 8'h00, "R7 ctrl clear");

    // R8 power fail blocks writes
    pwr_fail = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd0; req_wdata = 8'h55;
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (req_ready) seen++;
      end
      check("R8 req_ready during power fail", 32'(seen), 0);
    end
    req_valid = 1'b0;
    pwr_fail = 1'b0;
    @(negedge clk);
    xfer(1'b0, 3'd0, 8'h00, 8'h00, "R8 write blocked");

    // R9 back-pressure
    rsp_ready = 1'b0;
    exp_q.push_back(8'h00);
    tag_q.push_back("R9 held response");
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd4;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 rsp_valid held", 32'(rsp_valid), 1);
    check("R9 req_ready while pending", 32'(req_ready), 0);
    rsp_ready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check("R9 single response", 32'(rsp_valid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule